// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel words from a host into asynchronous serial frames on a single output line. A frame is a low start bit, then 8 or 9 data bits with the least significant bit first, then a high stop bit. Between frames the line rests high. A one-word holding register sits in front of the frame shifter. The host can therefore queue the next word while the current frame is still on the line.

The shifter takes a new word only after the stop bit of the current frame has run its full length. The move from holding register to shifter costs one clock. During that clock the line stays high and the shifter reports itself idle. Two status outputs tell the host what is going on. One is high while the holding register can take a word, and this one drives the interrupt. The other is high while the shifter is idle, and it has no interrupt. The bit period comes from an 8-bit divisor and a speed select input. An optional ninth data bit is latched together with each word, so software can use it for parity.

Top module: `uart_hold_tx`

## Requirements
- R1: While no frame is being shifted, `txd` is high.
- R2: A frame is a low start bit, then `wr_data` bit 0 through bit 7 in that order, then a high stop bit.
- R3: When `nine_bit` is high at the time a word moves into the shifter, the frame has a ninth data bit after data bit 7. That bit is the value of `wr_bit9` latched together with the word when it was written.
- R4: Each bit lasts 16×(`divisor`+1) clocks when `fast_sel` is high, and 64×(`divisor`+1) clocks when it is low.
- R5: A word held while a frame is in progress moves into the shifter only after that frame's stop bit has lasted its full period. `shift_empty` is then high for exactly one clock before the next start bit.
- R6: A word written while the shifter is idle shows `hold_empty` low for one clock. At the next clock edge the word moves into the shifter in one clock, `hold_empty` rises, and `txd` goes low in the same cycle.
- R7: `hold_empty` falls only when a word is written, and rises only when a word moves into the shifter (or on R8). A pending word keeps it low for the whole of the current frame.
- R8: `hold_empty` is high as soon as `tx_en` is high and no word is pending. While `tx_en` is low, `hold_empty` is low, writes are ignored, and any frame in progress is abandoned from the next clock edge (`txd` high, `shift_empty` high).
- R9: A write while a word is already pending replaces the pending word, and only the last word written is sent.
- R10: `shift_empty` is high exactly when no frame is being shifted.
- R11: `irq` equals `hold_empty` AND `irq_en`.
- R12: After reset, `txd` is high, `shift_empty` is high, and `hold_empty` and `irq` are low while `tx_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmitter enable |
| nine_bit | input | 1 | Selects 9-bit frames |
| fast_sel | input | 1 | Selects the ×16 bit period instead of ×64 |
| divisor | input | 8 | Bit-period divisor N |
| wr_stb | input | 1 | One-clock write strobe for the holding register |
| wr_data | input | 8 | Word to be sent |
| wr_bit9 | input | 1 | Ninth bit, latched with the word |
| irq_en | input | 1 | Interrupt enable |
| txd | output | 1 | Serial line |
| hold_empty | output | 1 | Holding register can take a word |
| shift_empty | output | 1 | Shifter idle |
| irq | output | 1 | Interrupt request |

## Verification
Several words are sent and checked bit by bit at the middle of each bit: 0x3C and 0xA5 in 8-bit mode, and 0x00 with a set ninth bit and 0xFF with a clear one in 9-bit mode. These catch a swapped bit order, a missing or misplaced ninth bit, and a wrong stop level. The start-bit length is measured at both speeds, which separates the two multipliers from each other and from a divisor that is off by one. Three write patterns are also tried. A lone write to an idle shifter exposes the load delay. A write during a frame shows whether the reload waits for the stop bit and whether the one-clock idle gap appears. A double write during a frame shows whether the pending word is overwritten or queued.

// File: rtl/uart_hold_tx_pkg.sv
package uart_hold_tx_pkg;
    localparam int DATA_W  = 8;
    localparam int WORD_W  = DATA_W + 1;
    localparam int FRAME_W = WORD_W + 2;
    localparam int IDX_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic              full;
        logic [WORD_W-1:0] word;
    } hold_st_t;

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] sr;
        logic [IDX_W-1:0]   idx;
        logic               nine;
    } shift_st_t;
endpackage

// File: rtl/uart_hold_tx_baud.sv
module uart_hold_tx_baud #(
    parameter int DIV_W    = 8,
    parameter int FAST_MUL = 16,
    parameter int SLOW_MUL = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             fast,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    localparam int PER_W = DIV_W + $clog2(SLOW_MUL) + 1;

    logic [PER_W-1:0] period;
    logic [PER_W-1:0] cnt_d, cnt_q;

    always_comb begin
        period = PER_W'(fast ? FAST_MUL : SLOW_MUL) * (PER_W'(divisor) + PER_W'(1));
        tick   = run && !restart && (cnt_q == period - PER_W'(1));
        cnt_d  = cnt_q + PER_W'(1);
        if (!run || restart || tick) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4: a bit never ends on two consecutive clocks (period >= 16)
    p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/uart_hold_tx_hold.sv
module uart_hold_tx_hold
    import uart_hold_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wbit9,
    input  logic              take,
    output logic              full,
    output logic [WORD_W-1:0] word
);
    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.full = 1'b0;
        end
        if (wr) begin
            st_d.full = 1'b1;
            st_d.word = {wbit9, wdata};
        end
        if (clr) begin
            st_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full = st_q.full;
    assign word = st_q.word;

    // R9: a write during a pending word keeps the register full
    p_overwrite_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.full && wr && !clr) |=> st_q.full);
    // R7: a move out without a new write leaves it empty
    p_take_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr) |=> !st_q.full);
endmodule

// File: rtl/uart_hold_tx_shift.sv
module uart_hold_tx_shift
    import uart_hold_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              nine,
    input  logic              tick,
    output logic              busy,
    output logic              txd
);
    shift_st_t st_d, st_q;
    logic      last;

    always_comb begin
        st_d = st_q;
        last = (st_q.idx == (st_q.nine ? IDX_W'(FRAME_W - 1) : IDX_W'(FRAME_W - 2)));
        if (load) begin
            st_d.busy = 1'b1;
            st_d.idx  = '0;
            st_d.nine = nine;
            st_d.sr   = {1'b1, (nine ? word[WORD_W-1] : 1'b1), word[DATA_W-1:0], 1'b0};
        end else if (st_q.busy && tick) begin
            st_d.sr  = {1'b1, st_q.sr[FRAME_W-1:1]};
            st_d.idx = st_q.idx + IDX_W'(1);
            if (last) begin
                st_d.busy = 1'b0;
            end
        end
        if (clr) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{busy: 1'b0, sr: '1, idx: '0, nine: 1'b0};
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign txd  = st_q.busy ? st_q.sr[0] : 1'b1;

    // R5: no frame ends before its stop bit is finished
    p_hold_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !(tick && last) && !clr) |=> st_q.busy);
    // R2: the final bit of every frame is high
    p_stop_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && last) |-> txd);
endmodule

// File: rtl/uart_hold_tx.sv
module uart_hold_tx
    import uart_hold_tx_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int FAST_MUL = 16,
    parameter int SLOW_MUL = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             nine_bit,
    input  logic             fast_sel,
    input  logic [DIV_W-1:0] divisor,
    input  logic             wr_stb,
    input  logic [7:0]       wr_data,
    input  logic             wr_bit9,
    input  logic             irq_en,
    output logic             txd,
    output logic             hold_empty,
    output logic             shift_empty,
    output logic             irq
);
    logic              full, busy, take, tick, clr, wr;
    logic [WORD_W-1:0] word;

    assign clr  = !tx_en;
    assign wr   = tx_en && wr_stb;
    assign take = tx_en && full && !busy;

    uart_hold_tx_hold u_hold (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr(wr), .wdata(wr_data),
        .wbit9(wr_bit9), .take(take), .full(full), .word(word)
    );

    uart_hold_tx_baud #(.DIV_W(DIV_W), .FAST_MUL(FAST_MUL), .SLOW_MUL(SLOW_MUL)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(busy), .restart(take),
        .fast(fast_sel), .divisor(divisor), .tick(tick)
    );

    uart_hold_tx_shift u_shift (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load(take), .word(word),
        .nine(nine_bit), .tick(tick), .busy(busy), .txd(txd)
    );

    assign hold_empty  = tx_en && !full;
    assign shift_empty = !busy;
    assign irq         = hold_empty && irq_en;

    // R6: a move into the shifter starts the frame with a low start bit
    p_start_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (!txd && !shift_empty));
    // R7: an accepted write makes the holding register non-empty
    p_write_fills_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && tx_en) |=> (!hold_empty || !tx_en));
    // R1: idle line is high
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        shift_empty |-> txd);
endmodule

// File: tb/test_uart_hold_tx.sv
`timescale 1ns/1ps
module test_uart_hold_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0, nine_bit = 1'b0, fast_sel = 1'b1;
    logic [7:0] divisor = 8'd0;
    logic       wr_stb = 1'b0, wr_bit9 = 1'b0, irq_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       txd, hold_empty, shift_empty, irq;

    int total = 0;
    int bad   = 0;
    int per   = 16;

    always #2.5 clk = ~clk;

    uart_hold_tx i_uart_hold_tx (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .nine_bit(nine_bit),
        .fast_sel(fast_sel), .divisor(divisor), .wr_stb(wr_stb),
        .wr_data(wr_data), .wr_bit9(wr_bit9), .irq_en(irq_en),
        .txd(txd), .hold_empty(hold_empty), .shift_empty(shift_empty), .irq(irq)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic write_word(input logic [7:0] d, input logic b9);
        wr_data = d; wr_bit9 = b9; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (!(shift_empty && hold_empty) && n < 20000) begin
            @(negedge clk); n++;
        end
        repeat (3) @(negedge clk);
    endtask

    // returns at the middle of the stop bit
    task automatic recv(input int nb, output logic [8:0] v, output logic stop_ok,
                        output logic got);
        int n = 0;
        v = '0; stop_ok = 1'b0; got = 1'b0;
        while (txd !== 1'b0 && n < 4000) begin
            @(negedge clk); n++;
        end
        if (txd !== 1'b0) return;
        repeat (per / 2) @(negedge clk);
        if (txd !== 1'b0) return;
        got = 1'b1;
        for (int i = 0; i < nb; i++) begin
            repeat (per) @(negedge clk);
            v[i] = txd;
        end
        repeat (per) @(negedge clk);
        stop_ok = (txd === 1'b1);
    endtask

    task automatic t_reset();
        chk(txd === 1'b1, "R12", "reset txd", txd, 1);
        chk(shift_empty === 1'b1, "R12", "reset shift_empty", shift_empty, 1);
        chk(hold_empty === 1'b0, "R12", "reset hold_empty", hold_empty, 0);
        chk(irq === 1'b0, "R12", "reset irq", irq, 0);
    endtask

    task automatic t_enable();
        logic line_ok = 1'b1;
        write_word(8'h55, 1'b0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) line_ok = 1'b0;
        end
        chk(line_ok, "R8", "write while disabled ignored, txd idle", 0, 1);
        chk(hold_empty === 1'b0, "R8", "hold_empty while disabled", hold_empty, 0);
        tx_en = 1'b1;
        #0.1;
        chk(hold_empty === 1'b1, "R8", "hold_empty on enable", hold_empty, 1);
        @(negedge clk);
        chk(irq === 1'b0, "R11", "irq masked", irq, 0);
        irq_en = 1'b1;
        #0.1;
        chk(irq === 1'b1, "R11", "irq enabled", irq, 1);
    endtask

    task automatic t_single();
        int lo = 0;
        per = 16;
        write_word(8'hA5, 1'b0);
        chk(hold_empty === 1'b0, "R6", "hold_empty after write", hold_empty, 0);
        chk(irq === 1'b0, "R11", "irq after write", irq, 0);
        chk(txd === 1'b1, "R6", "txd one clock after write", txd, 1);
        @(negedge clk);
        chk(hold_empty === 1'b1, "R6", "hold_empty after move", hold_empty, 1);
        chk(txd === 1'b0, "R6", "start bit begins", txd, 0);
        chk(shift_empty === 1'b0, "R10", "shift_empty during frame", shift_empty, 0);
        while (txd === 1'b0 && lo < 2000) begin
            lo++; @(negedge clk);
        end
        chk(lo == 16, "R4", "fast start-bit clocks", lo, 16);
        wait_idle();
        chk(shift_empty === 1'b1, "R10", "shift_empty after frame", shift_empty, 1);
    endtask

    task automatic t_slow();
        int lo = 0;
        fast_sel = 1'b0; divisor = 8'd1;
        write_word(8'h01, 1'b0);
        @(negedge clk);
        while (txd === 1'b0 && lo < 2000) begin
            lo++; @(negedge clk);
        end
        chk(lo == 128, "R4", "slow start-bit clocks", lo, 128);
        wait_idle();
        fast_sel = 1'b1; divisor = 8'd0; per = 16;
    endtask

    task automatic t_content();
        logic [8:0] v; logic s, g;
        write_word(8'h3C, 1'b0);
        recv(8, v, s, g);
        chk(g && v[7:0] == 8'h3C, "R2", "8-bit word 3C", int'(v), 'h3C);
        chk(s, "R2", "stop bit of 3C", s, 1);
        wait_idle();
        write_word(8'hA5, 1'b1);
        recv(8, v, s, g);
        chk(g && v[7:0] == 8'hA5, "R2", "8-bit word A5", int'(v), 'hA5);
        chk(s, "R2", "stop bit follows bit 7 when nine_bit low", s, 1);
        wait_idle();
    endtask

    task automatic t_nine();
        logic [8:0] v; logic s, g;
        nine_bit = 1'b1;
        write_word(8'h00, 1'b1);
        recv(9, v, s, g);
        chk(g && v == 9'h100, "R3", "ninth bit set", int'(v), 'h100);
        chk(s, "R3", "stop after ninth bit", s, 1);
        wait_idle();
        write_word(8'hFF, 1'b0);
        recv(9, v, s, g);
        chk(g && v == 9'h0FF, "R3", "ninth bit clear", int'(v), 'h0FF);
        wait_idle();
        nine_bit = 1'b0;
    endtask

    task automatic t_b2b();
        logic [8:0] v; logic s, g;
        int gap = 0; int n = 0;
        write_word(8'h5A, 1'b0);
        repeat (3) @(negedge clk);
        write_word(8'hC3, 1'b0);
        recv(8, v, s, g);
        chk(g && v[7:0] == 8'h5A, "R2", "first of pair", int'(v), 'h5A);
        chk(hold_empty === 1'b0, "R5", "pending word held through stop bit", hold_empty, 0);
        while (txd !== 1'b0 && n < 100) begin
            if (shift_empty === 1'b1) gap++;
            @(negedge clk); n++;
        end
        chk(gap == 1, "R5", "idle clocks between frames", gap, 1);
        recv(8, v, s, g);
        chk(g && v[7:0] == 8'hC3, "R5", "second of pair", int'(v), 'hC3);
        wait_idle();
        chk(hold_empty === 1'b1, "R7", "hold_empty after both sent", hold_empty, 1);
    endtask

    task automatic t_over();
        logic [8:0] v; logic s, g;
        logic quiet = 1'b1;
        write_word(8'h11, 1'b0);
        repeat (5) @(negedge clk);
        write_word(8'h22, 1'b0);
        write_word(8'h33, 1'b0);
        recv(8, v, s, g);
        chk(g && v[7:0] == 8'h11, "R9", "frame before overwrite", int'(v), 'h11);
        recv(8, v, s, g);
        chk(g && v[7:0] == 8'h33, "R9", "overwritten word sent", int'(v), 'h33);
        repeat (per) @(negedge clk);
        for (int i = 0; i < 12 * per; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) quiet = 1'b0;
        end
        chk(quiet, "R9", "no third frame", 0, 1);
    endtask

    task automatic t_disable();
        write_word(8'h77, 1'b0);
        repeat (30) @(negedge clk);
        chk(shift_empty === 1'b0, "R10", "busy mid frame", shift_empty, 0);
        tx_en = 1'b0;
        @(negedge clk);
        chk(txd === 1'b1, "R8", "txd after disable", txd, 1);
        chk(shift_empty === 1'b1, "R8", "shift_empty after disable", shift_empty, 1);
        chk(hold_empty === 1'b0, "R8", "hold_empty after disable", hold_empty, 0);
        chk(txd === 1'b1, "R1", "idle line high", txd, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_single();
        t_slow();
        t_content();
        t_nine();
        t_b2b();
        t_over();
        t_disable();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule